// File: doc/BRIEF.md
# Keyboard Scan Reply Encoder

This block is the keyboard side of a two-wire bit-serial link to a host processor. A scanner upstream reports key events: one press or one release per cycle, each carrying a 6-bit key code and a 4-bit modifier field. The block keeps the completed presses in a small queue. It also tracks the most recently pressed key while that key stays down.

The host sends 4-bit command codes one bit at a time, most significant bit first. Code 8 asks for the buffered keys. On that code the block builds a reply and presents it one bit per host read strobe. The reply opens with a status nibble. The three low bits of that nibble give how many keys follow. Bit 3 says whether the last key in the reply is still held down. Each key entry then follows as a modifier nibble and a key code.

If a key was announced as still held, its later release puts the same key back in the queue. The next reply then reports it again with bit 3 clear. Any other command code is ignored.

Top module: `key_reply_encoder`

## Requirements
- R1: Command bits are taken on `cmd_bit_valid`, most significant first, in groups of 4. When a group equals 8, the reply starts on the next clock edge, with `reply_busy` high. Any other code starts nothing. Command bits that arrive while a reply is in progress are discarded.
- R2: The first 4 reply bits form the status nibble, sent bit 3 first. Bits 2..0 hold the number of key entries that follow: the smaller of the queue fill and 7.
- R3: Each key entry is 10 bits: the 4-bit modifier value as given on `key_mods`, then the 6-bit code from `key_code`, both most significant bit first. Entries go out oldest first and leave the queue.
- R4: When the reply carries one or more entries, status bit 3 is 1 only if the last entry is the most recent press and that key is still down.
- R5: When the queue is empty, the reply is the status nibble alone. Its bits 2..0 are zero and bit 3 is 1 if the most recent pressed key is still down.
- R6: The queue holds 8 entries. A press or re-report that arrives while it is full is dropped. A fill of 8 is reported as 7, and the eighth entry goes out in the following reply.
- R7: Releasing the most recent key after a reply flagged it as held queues that key again, with the same modifiers and code. Two kinds of release queue nothing: the release of a key not yet reported as held, and the release of a key other than the most recent press.
- R8: `reply_bit` stays put until `rd_strobe`. Each strobe moves to the next bit. The strobe on the last bit ends the reply: `reply_busy` falls and `reply_bit` reads 0 while idle.
- R9: After reset the block is idle. The queue is empty and no key counts as held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| key_valid | input | 1 | A key event is present this cycle |
| key_press | input | 1 | 1 for a press, 0 for a release |
| key_code | input | 6 | Key code of the event |
| key_mods | input | 4 | Modifier bits sampled with the press |
| cmd_bit_valid | input | 1 | One command bit is present |
| cmd_bit | input | 1 | Command bit value |
| rd_strobe | input | 1 | Host has sampled the current reply bit |
| reply_bit | output | 1 | Current reply bit |
| reply_busy | output | 1 | A reply is being presented |

## Verification
The assertions take three things for granted about the host. It strobes only while `reply_busy` is high. It sends a whole 4-bit command before expecting a reply. The key source delivers at most one event per cycle. The stimulus follows these rules: it drives every input on the falling edge, sends commands only when the block is idle, pulses `rd_strobe` for exactly one cycle per bit during a reply, and separates key events by idle cycles. Some strobes are held back for an extra cycle, to show that the bit holds still until it is sampled.

// File: rtl/kbr_pkg.sv
package kbr_pkg;
   localparam int unsigned KBR_READ_KEYS_CODE = 8;

   function automatic int unsigned kbr_min(input int unsigned a, input int unsigned b);
      return (a < b) ? a : b;
   endfunction
endpackage

// File: rtl/kbr_fifo.sv
module kbr_fifo #(
   parameter int unsigned WIDTH = 10,
   parameter int unsigned DEPTH = 8,
   localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic [CW-1:0]    fill,
   output logic             full
);
   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic             do_push, do_pop;

   assign full    = (fill == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && (fill != '0);
   assign head    = mem[rd_ptr];

   generate
      if ((1 << AW) == DEPTH) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   fill <= fill + 1'b1;
            2'b01:   fill <= fill - 1'b1;
            default: fill <= fill;
         endcase
      end
   end
endmodule

// File: rtl/kbr_cmd_rx.sv
module kbr_cmd_rx #(
   parameter int unsigned CMD_W    = 4,
   parameter int unsigned CMD_CODE = 8,
   localparam int unsigned NW      = $clog2(CMD_W)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic bit_valid,
   input  logic bit_in,
   output logic hit
);
   logic [CMD_W-1:0] sh;
   logic [CMD_W-1:0] word;
   logic [NW-1:0]    nbits;
   logic             last;

   assign word = {sh[CMD_W-2:0], bit_in};
   assign last = (nbits == NW'(CMD_W - 1));
   assign hit  = enable && bit_valid && last && (word == CMD_W'(CMD_CODE));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh    <= '0;
         nbits <= '0;
      end else if (enable && bit_valid) begin
         sh    <= word;
         nbits <= last ? '0 : nbits + 1'b1;
      end
   end
endmodule

// File: rtl/kbr_reply_ser.sv
module kbr_reply_ser #(
   parameter int unsigned ENTRY_W = 10,
   parameter int unsigned STAT_W  = 4,
   parameter int unsigned KEYS_W  = 3,
   localparam int unsigned BW     = $clog2(ENTRY_W + 1),
   localparam int unsigned PAD    = ENTRY_W - STAT_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [STAT_W-1:0]  load_status,
   input  logic [KEYS_W-1:0]  load_keys,
   input  logic               strobe,
   input  logic [ENTRY_W-1:0] head,
   output logic               pop,
   output logic               bit_out,
   output logic               busy
);
   logic [ENTRY_W-1:0] sh;
   logic [BW-1:0]      bits_left;
   logic [KEYS_W-1:0]  keys_left;
   logic               step, more_bits;

   assign step      = busy && strobe;
   assign more_bits = (bits_left > BW'(1));
   assign pop       = step && !more_bits && (keys_left != '0);
   assign bit_out   = sh[ENTRY_W-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         sh        <= '0;
         bits_left <= '0;
         keys_left <= '0;
      end else if (load) begin
         busy      <= 1'b1;
         sh        <= {load_status, {PAD{1'b0}}};
         bits_left <= BW'(STAT_W);
         keys_left <= load_keys;
      end else if (step) begin
         if (more_bits) begin
            sh        <= sh << 1;
            bits_left <= bits_left - 1'b1;
         end else if (keys_left != '0) begin
            sh        <= head;
            bits_left <= BW'(ENTRY_W);
            keys_left <= keys_left - 1'b1;
         end else begin
            busy      <= 1'b0;
            sh        <= '0;
            bits_left <= '0;
         end
      end
   end
endmodule

// File: rtl/key_reply_encoder.sv
module key_reply_encoder #(
   parameter int unsigned CODE_W  = 6,
   parameter int unsigned MOD_W   = 4,
   parameter int unsigned DEPTH   = 8,
   parameter int unsigned CNT_W   = 3,
   parameter int unsigned CMD_W   = 4,
   parameter int unsigned CMD_KEY = kbr_pkg::KBR_READ_KEYS_CODE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_valid,
   input  logic              key_press,
   input  logic [CODE_W-1:0] key_code,
   input  logic [MOD_W-1:0]  key_mods,
   input  logic              cmd_bit_valid,
   input  logic              cmd_bit,
   input  logic              rd_strobe,
   output logic              reply_bit,
   output logic              reply_busy
);
   localparam int unsigned ENTRY_W = MOD_W + CODE_W;
   localparam int unsigned STAT_W  = CNT_W + 1;
   localparam int unsigned MAXK    = (1 << CNT_W) - 1;
   localparam int unsigned CW      = $clog2(DEPTH + 1);

   if (ENTRY_W <= STAT_W) begin : g_bad_entry
      $error("key entry must be wider than the status nibble");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("queue depth must be at least 2");
   end
   if (CMD_W < 2 || CMD_KEY >= (1 << CMD_W)) begin : g_bad_cmd
      $error("command code does not fit the command width");
   end

   logic [ENTRY_W-1:0] head, push_data;
   logic [CW-1:0]      fill_cnt;
   logic               full, push, pop, load;
   logic               held_valid, held_in_fifo, held_reported;
   logic [CODE_W-1:0]  held_code;
   logic [MOD_W-1:0]   held_mods;
   logic               all_out, flag, load_rep, rel_match;
   logic [CNT_W-1:0]   take;
   logic [STAT_W-1:0]  status;

   // how many keys this reply carries, and whether the last one is still down
   assign all_out  = (fill_cnt <= CW'(MAXK));
   assign take     = all_out ? CNT_W'(fill_cnt) : CNT_W'(MAXK);
   assign flag     = (fill_cnt == '0) ? held_valid : (held_valid && held_in_fifo && all_out);
   assign status   = {flag, take};
   assign load_rep = load && flag && (fill_cnt != '0);

   assign rel_match = key_valid && !key_press && held_valid && (key_code == held_code);
   assign push      = key_valid && (key_press || (rel_match && (held_reported || load_rep)));
   assign push_data = key_press ? {key_mods, key_code} : {held_mods, held_code};

   kbr_cmd_rx #(.CMD_W(CMD_W), .CMD_CODE(CMD_KEY)) u_rx (
      .clk(clk), .rst_n(rst_n), .enable(!reply_busy),
      .bit_valid(cmd_bit_valid), .bit_in(cmd_bit), .hit(load)
   );

   kbr_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_q (
      .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
      .pop(pop), .head(head), .fill(fill_cnt), .full(full)
   );

   kbr_reply_ser #(.ENTRY_W(ENTRY_W), .STAT_W(STAT_W), .KEYS_W(CNT_W)) u_ser (
      .clk(clk), .rst_n(rst_n), .load(load), .load_status(status),
      .load_keys(take), .strobe(rd_strobe), .head(head),
      .pop(pop), .bit_out(reply_bit), .busy(reply_busy)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_valid    <= 1'b0;
         held_in_fifo  <= 1'b0;
         held_reported <= 1'b0;
         held_code     <= '0;
         held_mods     <= '0;
      end else begin
         if (load && (fill_cnt != '0) && all_out) begin
            held_in_fifo <= 1'b0;
            if (flag) held_reported <= 1'b1;
         end
         if (key_valid && key_press) begin
            held_valid    <= 1'b1;
            held_code     <= key_code;
            held_mods     <= key_mods;
            held_in_fifo  <= !full;
            held_reported <= 1'b0;
         end else if (rel_match) begin
            held_valid    <= 1'b0;
            held_in_fifo  <= 1'b0;
            held_reported <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/kbr_checker.sv
module kbr_checker #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned CW    = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cmd_bit_valid,
   input logic          rd_strobe,
   input logic          reply_busy,
   input logic          reply_bit,
   input logic [CW-1:0] fill
);
   AST_START_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reply_busy) |-> $past(cmd_bit_valid)); // R1

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= CW'(DEPTH)); // R6

   AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (reply_busy && !rd_strobe) |=> ($stable(reply_bit) && reply_busy)); // R8

   AST_END_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(reply_busy) |-> $past(rd_strobe)); // R8

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !reply_busy |-> !reply_bit); // R8
endmodule

bind key_reply_encoder kbr_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_bit_valid(cmd_bit_valid),
   .rd_strobe(rd_strobe), .reply_busy(reply_busy),
   .reply_bit(reply_bit), .fill(fill_cnt)
);

// File: tb/tb_key_reply_encoder.sv
module tb_key_reply_encoder;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       key_valid = 1'b0, key_press = 1'b0;
   logic [5:0] key_code = '0;
   logic [3:0] key_mods = '0;
   logic       cmd_bit_valid = 1'b0, cmd_bit = 1'b0, rd_strobe = 1'b0;
   logic       reply_bit, reply_busy;
   int         errors = 0, checks = 0;
   bit         finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   key_reply_encoder dut (
      .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_press(key_press),
      .key_code(key_code), .key_mods(key_mods), .cmd_bit_valid(cmd_bit_valid),
      .cmd_bit(cmd_bit), .rd_strobe(rd_strobe), .reply_bit(reply_bit),
      .reply_busy(reply_busy)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [79:0] got, input logic [79:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic key_evt(input bit press, input logic [5:0] code, input logic [3:0] mods);
      @(negedge clk);
      key_valid = 1'b1; key_press = press; key_code = code; key_mods = mods;
      @(negedge clk);
      key_valid = 1'b0;
      @(negedge clk);
   endtask

   task automatic tap(input logic [5:0] code, input logic [3:0] mods);
      key_evt(1'b1, code, mods);
      key_evt(1'b0, code, mods);
   endtask

   task automatic send_cmd(input logic [3:0] code);
      for (int i = 3; i >= 0; i--) begin
         @(negedge clk);
         cmd_bit_valid = 1'b1; cmd_bit = code[i];
      end
      @(negedge clk);
      cmd_bit_valid = 1'b0;
   endtask

   // sends command 8 and reads n bits; exp holds them in its low n bits, first bit highest
   task automatic read_reply(input string req, input int n, input logic [79:0] exp);
      logic [79:0] got = '0;
      bit          held_ok = 1'b1;
      send_cmd(4'd8);
      check(reply_busy === 1'b1, req, "reply start", {79'b0, reply_busy}, 80'd1);
      for (int i = 0; i < n; i++) begin
         got = {got[78:0], reply_bit};
         if (i % 3 == 1) begin
            @(negedge clk);
            if (reply_bit !== got[0] || reply_busy !== 1'b1) held_ok = 1'b0;
         end
         rd_strobe = 1'b1;
         @(negedge clk);
         rd_strobe = 1'b0;
      end
      check(got == exp, req, "reply bits", got, exp);
      check(held_ok, "R8", "bit held without strobe", {79'b0, held_ok}, 80'd1);
      check(reply_busy === 1'b0 && reply_bit === 1'b0, "R8", "idle after last bit",
            {78'b0, reply_busy, reply_bit}, 80'd0);
   endtask

   task automatic t_reset;
      check(reply_busy === 1'b0 && reply_bit === 1'b0, "R9", "reset outputs",
            {78'b0, reply_busy, reply_bit}, 80'd0);
      read_reply("R9", 4, 80'b0000); // R5 empty, nothing held
   endtask

   task automatic t_two_taps;
      tap(6'd5, 4'h1);
      tap(6'h2A, 4'h3);
      read_reply("R3", 24, {56'b0, 4'b0010, 4'h1, 6'd5, 4'h3, 6'h2A}); // R2 count 2
   endtask

   task automatic t_other_cmd;
      bit stayed = 1'b1;
      tap(6'd3, 4'h0);
      send_cmd(4'd9);
      for (int i = 0; i < 4; i++) begin
         if (reply_busy !== 1'b0) stayed = 1'b0;
         @(negedge clk);
      end
      check(stayed, "R1", "code 9 ignored", {79'b0, stayed}, 80'd1);
      read_reply("R1", 14, {66'b0, 4'b0001, 4'h0, 6'd3});
   endtask

   task automatic t_held_last;
      tap(6'h0C, 4'h4);
      key_evt(1'b1, 6'h33, 4'h2);
      read_reply("R4", 24, {56'b0, 4'b1010, 4'h4, 6'h0C, 4'h2, 6'h33});
      read_reply("R5", 4, 80'b1000);
      key_evt(1'b0, 6'h33, 4'h0);
      read_reply("R7", 14, {66'b0, 4'b0001, 4'h2, 6'h33});
      read_reply("R7", 4, 80'b0000);
   endtask

   task automatic t_unreported_release;
      key_evt(1'b1, 6'h15, 4'h8);
      key_evt(1'b0, 6'h15, 4'h0);
      read_reply("R7", 14, {66'b0, 4'b0001, 4'h8, 6'h15});
      read_reply("R7", 4, 80'b0000);
   endtask

   task automatic t_two_held;
      key_evt(1'b1, 6'd7, 4'h1);
      key_evt(1'b1, 6'd9, 4'h5);
      read_reply("R4", 24, {56'b0, 4'b1010, 4'h1, 6'd7, 4'h5, 6'd9});
      key_evt(1'b0, 6'd7, 4'h0);
      read_reply("R7", 4, 80'b1000);
      key_evt(1'b0, 6'd9, 4'h0);
      read_reply("R7", 14, {66'b0, 4'b0001, 4'h5, 6'd9});
   endtask

   task automatic t_overflow;
      logic [79:0] exp = 80'b0111;
      for (int k = 1; k <= 9; k++) tap(6'(k), 4'(k));
      for (int k = 1; k <= 7; k++) exp = (exp << 10) | {70'b0, 4'(k), 6'(k)};
      read_reply("R6", 74, exp);
      read_reply("R6", 14, {66'b0, 4'b0001, 4'd8, 6'd8});
      read_reply("R6", 4, 80'b0000);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_two_taps();
      t_other_cmd();
      t_held_last();
      t_unreported_release();
      t_two_held();
      t_overflow();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule